// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers a set of level-sensitive peripheral request lines and turns them into two processor-facing requests: a fast request (`fiq_o`) and a normal request (`irq_o`). Software classifies each source as fast or normal and enables the sources it wants to hear from. Normal sources may also be bound to numbered vector slots. Each slot holds a handler address, and a lower slot number means higher priority. A normal source bound to no slot shares one programmable default handler address.

The processor reads the vector register to fetch the handler address. If a vectored slot is winning at that moment, the read also puts that slot in service. While any slot is in service, only strictly higher-priority slots can raise `irq_o` or change the vector value. Any write to the vector register ends service of the highest-priority slot in service. Service can therefore nest one level per slot.

The register bus is a single-cycle word port: `bus_addr_i` selects a register, `bus_wr_i` writes it on the clock edge, and `bus_rdata_o` follows the address combinationally.

Top module: `vic_irq_ctrl`

## Requirements
- R1: Bit n of the class register (address 0x03) set to 1 makes source n a fast source. `fiq_o` is high exactly when some enabled fast source is requesting. The class register reads back what was written.
- R2: When no slot is in service, `irq_o` is high exactly when some enabled source with class bit 0 is requesting.
- R3: A source whose bit in the enable register (address 0x04) is 0 affects neither output nor the classified status registers. It still shows in the raw status register.
- R4: Address 0x00 reads the raw request lines. Address 0x01 reads requesting, enabled fast sources. Address 0x02 reads requesting, enabled normal sources. One bit per source, with source n at bit n.
- R5: Slot n control sits at address 0x10+n: bit 5 marks the slot valid, and bits 3:0 give its source number. Slot n address sits at 0x20+n. A slot is active when it is valid and its source's bit is set in the normal status register. Reading the vector register (0x05) returns the address of the lowest-numbered active slot.
- R6: With no active slot, the vector register returns the default address register (0x06).
- R7: A vector read while a slot wins puts that slot in service. Afterwards `irq_o` and the vector value consider only slots numbered below the lowest slot in service.
- R8: Any write to the vector register takes the lowest-numbered in-service slot out of service, and arbitration then reopens to the slots it had masked.
- R9: After reset every register reads 0 and both outputs are low.
- R10: A vector read that returns the default address puts nothing in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req_i | input | NSRC | Level request lines, one per source |
| bus_rd_i | input | 1 | Read strobe; only matters for the vector register |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | ABW | Word register address |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Read data for the addressed register |
| fiq_o | output | 1 | Fast interrupt request to the core |
| irq_o | output | 1 | Normal interrupt request to the core |

## Verification
The assertions assume that request lines are synchronous levels. They also assume that read and write strobes are never raised together, and that every valid slot names a source number below NSRC. The bench changes requests and bus signals only on the falling clock edge and issues one bus operation per cycle. It programs only slot source fields within range, so the assumptions hold throughout.

// File: rtl/vic_pkg.sv
package vic_pkg;
    // Register word addresses
    localparam int unsigned REG_RAW       = 0;
    localparam int unsigned REG_FIQ_STAT  = 1;
    localparam int unsigned REG_IRQ_STAT  = 2;
    localparam int unsigned REG_CLASS     = 3;
    localparam int unsigned REG_ENABLE    = 4;
    localparam int unsigned REG_VECTOR    = 5;
    localparam int unsigned REG_DEFAULT   = 6;
    localparam int unsigned REG_SLOT_CTL  = 16;
    localparam int unsigned REG_SLOT_ADR  = 32;
    // Valid flag position inside a slot control word
    localparam int unsigned SLOT_VLD_BIT  = 5;
endpackage

// File: rtl/vic_prio_enc.sv
module vic_prio_enc #(
    parameter int unsigned N  = 16,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          valid,
    output logic [IW-1:0] idx
);
    always_comb begin
        valid = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

    always_comb begin
        if (valid) begin
            AST_LOWEST_WINS: assert (req[idx] && ((req & ((N'(1) << idx) - N'(1))) == '0)); // R5
        end
    end
endmodule

// File: rtl/vic_slot_match.sv
module vic_slot_match #(
    parameter int unsigned NSLOT = 16,
    parameter int unsigned NSRC  = 16,
    localparam int unsigned SW   = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]           irq_stat,
    input  logic [NSLOT-1:0]          slot_vld,
    input  logic [NSLOT-1:0][SW-1:0]  slot_src,
    input  logic [NSLOT-1:0]          limit_mask,
    output logic [NSLOT-1:0]          slot_act
);
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        assign slot_act[g] = slot_vld[g] & irq_stat[slot_src[g]] & limit_mask[g];
    end
endmodule

// File: rtl/vic_irq_ctrl.sv
module vic_irq_ctrl #(
    parameter int unsigned NSRC  = 16,
    parameter int unsigned NSLOT = 16,
    parameter int unsigned DW    = 32,
    parameter int unsigned ABW   = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_req_i,
    input  logic            bus_rd_i,
    input  logic            bus_wr_i,
    input  logic [ABW-1:0]  bus_addr_i,
    input  logic [DW-1:0]   bus_wdata_i,
    output logic [DW-1:0]   bus_rdata_o,
    output logic            fiq_o,
    output logic            irq_o
);
    import vic_pkg::*;

    localparam int unsigned SW  = $clog2(NSRC);
    localparam int unsigned SLW = $clog2(NSLOT);

    typedef struct packed {
        logic [NSRC-1:0]           cls;
        logic [NSRC-1:0]           en;
        logic [DW-1:0]             def_adr;
        logic [NSLOT-1:0]          slot_vld;
        logic [NSLOT-1:0][SW-1:0]  slot_src;
        logic [NSLOT-1:0][DW-1:0]  slot_adr;
        logic [NSLOT-1:0]          in_svc;
    } state_t;

    state_t s_d, s_q;

    logic [NSRC-1:0]  fiq_stat, irq_stat;
    logic [NSLOT-1:0] limit_mask, slot_act;
    logic             svc_valid, win_valid;
    logic [SLW-1:0]   svc_idx, win_idx;
    logic [DW-1:0]    vec_adr;
    logic             vec_sel;

    assign fiq_stat = src_req_i & s_q.en & s_q.cls;
    assign irq_stat = src_req_i & s_q.en & ~s_q.cls;
    assign vec_sel  = (bus_addr_i == ABW'(REG_VECTOR));

    // Lowest in-service slot sets the priority ceiling
    vic_prio_enc #(.N(NSLOT)) u_svc_enc (
        .req   (s_q.in_svc),
        .valid (svc_valid),
        .idx   (svc_idx)
    );

    assign limit_mask = svc_valid ? ((NSLOT'(1) << svc_idx) - NSLOT'(1)) : '1;

    vic_slot_match #(.NSLOT(NSLOT), .NSRC(NSRC)) u_match (
        .irq_stat   (irq_stat),
        .slot_vld   (s_q.slot_vld),
        .slot_src   (s_q.slot_src),
        .limit_mask (limit_mask),
        .slot_act   (slot_act)
    );

    vic_prio_enc #(.N(NSLOT)) u_win_enc (
        .req   (slot_act),
        .valid (win_valid),
        .idx   (win_idx)
    );

    assign vec_adr = win_valid ? s_q.slot_adr[win_idx] : s_q.def_adr;
    assign fiq_o   = |fiq_stat;
    assign irq_o   = svc_valid ? win_valid : |irq_stat;

    // Read mux
    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            ABW'(REG_RAW):      bus_rdata_o = DW'(src_req_i);
            ABW'(REG_FIQ_STAT): bus_rdata_o = DW'(fiq_stat);
            ABW'(REG_IRQ_STAT): bus_rdata_o = DW'(irq_stat);
            ABW'(REG_CLASS):    bus_rdata_o = DW'(s_q.cls);
            ABW'(REG_ENABLE):   bus_rdata_o = DW'(s_q.en);
            ABW'(REG_VECTOR):   bus_rdata_o = vec_adr;
            ABW'(REG_DEFAULT):  bus_rdata_o = s_q.def_adr;
            default: ;
        endcase
        for (int n = 0; n < NSLOT; n++) begin
            if (bus_addr_i == ABW'(REG_SLOT_CTL + n)) begin
                bus_rdata_o               = '0;
                bus_rdata_o[SLOT_VLD_BIT] = s_q.slot_vld[n];
                bus_rdata_o[SW-1:0]       = s_q.slot_src[n];
            end
            if (bus_addr_i == ABW'(REG_SLOT_ADR + n)) begin
                bus_rdata_o = s_q.slot_adr[n];
            end
        end
    end

    // Next-state
    always_comb begin
        s_d = s_q;
        if (bus_wr_i) begin
            case (bus_addr_i)
                ABW'(REG_CLASS):   s_d.cls     = bus_wdata_i[NSRC-1:0];
                ABW'(REG_ENABLE):  s_d.en      = bus_wdata_i[NSRC-1:0];
                ABW'(REG_DEFAULT): s_d.def_adr = bus_wdata_i;
                default: ;
            endcase
            for (int n = 0; n < NSLOT; n++) begin
                if (bus_addr_i == ABW'(REG_SLOT_CTL + n)) begin
                    s_d.slot_vld[n] = bus_wdata_i[SLOT_VLD_BIT];
                    s_d.slot_src[n] = bus_wdata_i[SW-1:0];
                end
                if (bus_addr_i == ABW'(REG_SLOT_ADR + n)) begin
                    s_d.slot_adr[n] = bus_wdata_i;
                end
            end
            if (vec_sel && svc_valid) begin
                s_d.in_svc[svc_idx] = 1'b0;
            end
        end else if (bus_rd_i && vec_sel && win_valid) begin
            s_d.in_svc[win_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.en == '0) |-> (!fiq_o && !irq_o)); // R3
    AST_FIQ_NEEDS_FAST_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> |(src_req_i & s_q.cls)); // R1
    AST_SVC_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && !bus_wr_i && vec_sel && win_valid) |=> s_q.in_svc[$past(win_idx)]); // R7
    AST_EOI_POPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && vec_sel && svc_valid) |=>
        ($countones(s_q.in_svc) + 1 == $past($countones(s_q.in_svc)))); // R8
    AST_DEFAULT_NO_SVC: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && !bus_wr_i && vec_sel && !win_valid) |=> $stable(s_q.in_svc)); // R10
endmodule

// File: tb/vic_irq_ctrl_test.sv
module vic_irq_ctrl_test;
    localparam int NSRC = 16, NSLOT = 16, DW = 32, ABW = 6;

    logic            clk = 0;
    logic            rst_n = 0;
    logic [NSRC-1:0] src_req = '0;
    logic            bus_rd = 0, bus_wr = 0;
    logic [ABW-1:0]  bus_addr = '0;
    logic [DW-1:0]   bus_wdata = '0;
    logic [DW-1:0]   bus_rdata;
    logic            fiq, irq;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    vic_irq_ctrl #(.NSRC(NSRC), .NSLOT(NSLOT), .DW(DW), .ABW(ABW)) uut (
        .clk(clk), .rst_n(rst_n), .src_req_i(src_req),
        .bus_rd_i(bus_rd), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .fiq_o(fiq), .irq_o(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = ABW'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
        #2;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1; bus_addr = ABW'(a);
        #2 d = bus_rdata;
        @(negedge clk);
        bus_rd = 0;
        #2;
    endtask

    task automatic peek(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 0; bus_addr = ABW'(a);
        #2 d = bus_rdata;
    endtask

    task automatic set_req(input logic [NSRC-1:0] v);
        @(negedge clk);
        src_req = v;
        #2;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check("R9 fiq after reset", 32'(fiq), 0);
        check("R9 irq after reset", 32'(irq), 0);
        peek(3, d); check("R9 class after reset", d, 0);
        peek(4, d); check("R9 enable after reset", d, 0);
        peek(5, d); check("R9 vector after reset", d, 0);
        peek(6, d); check("R9 default after reset", d, 0);
        peek(16, d); check("R9 slot ctl after reset", d, 0);
    endtask

    task automatic t_routing;
        logic [31:0] d;
        wr(3, 32'h0008);
        wr(4, 32'hFFFF);
        peek(3, d); check("R1 class readback", d, 32'h0008);
        set_req(16'h0008);
        check("R1 fast src raises fiq", 32'(fiq), 1);
        check("R2 fast src leaves irq", 32'(irq), 0);
        peek(1, d); check("R4 fiq status", d, 32'h0008);
        peek(2, d); check("R4 irq status", d, 0);
        set_req(16'h0020);
        check("R2 normal src raises irq", 32'(irq), 1);
        check("R1 normal src leaves fiq", 32'(fiq), 0);
        peek(2, d); check("R4 irq status normal", d, 32'h0020);
        peek(0, d); check("R4 raw status", d, 32'h0020);
    endtask

    task automatic t_enable;
        logic [31:0] d;
        wr(4, 32'hFF7F);
        set_req(16'h0080);
        check("R3 disabled src irq", 32'(irq), 0);
        check("R3 disabled src fiq", 32'(fiq), 0);
        peek(0, d); check("R3 raw shows disabled src", d, 32'h0080);
        peek(2, d); check("R3 irq status masks disabled", d, 0);
        wr(4, 32'hFFFF);
        wr(3, 32'h0000);
    endtask

    task automatic t_vector;
        logic [31:0] d;
        wr(16 + 2, 32'h24); wr(32 + 2, 32'hA4);
        wr(16 + 5, 32'h29); wr(32 + 5, 32'hB9);
        wr(6, 32'hDEF);
        peek(16 + 2, d); check("R5 slot ctl readback", d, 32'h24);
        set_req(16'h0200);
        peek(5, d); check("R5 single slot vector", d, 32'hB9);
        set_req(16'h0210);
        peek(5, d); check("R5 lower slot wins", d, 32'hA4);
        set_req(16'h0800);
        peek(5, d); check("R6 non-vectored default", d, 32'hDEF);
        check("R2 non-vectored irq", 32'(irq), 1);
        wr(16 + 5, 32'h09);
        set_req(16'h0200);
        peek(5, d); check("R5 invalid slot ignored", d, 32'hDEF);
        wr(16 + 5, 32'h29);
    endtask

    task automatic t_service;
        logic [31:0] d;
        set_req(16'h0210);
        rd(5, d); check("R5 vector read", d, 32'hA4);
        check("R7 irq masked in service", 32'(irq), 0);
        peek(5, d); check("R7 vector masked in service", d, 32'hDEF);
        wr(16 + 0, 32'h21); wr(32 + 0, 32'hC1);
        set_req(16'h0212);
        check("R7 higher slot pre-empts", 32'(irq), 1);
        peek(5, d); check("R7 higher slot vector", d, 32'hC1);
        rd(5, d); check("R7 nested read", d, 32'hC1);
        check("R7 nested irq masked", 32'(irq), 0);
        wr(5, 0);
        check("R8 eoi reopens slot0", 32'(irq), 1);
        set_req(16'h0210);
        check("R8 slot2 still in service", 32'(irq), 0);
        wr(5, 0);
        check("R8 second eoi irq", 32'(irq), 1);
        peek(5, d); check("R8 second eoi vector", d, 32'hA4);
    endtask

    task automatic t_nonvec;
        logic [31:0] d;
        set_req(16'h0800);
        rd(5, d); check("R10 default read", d, 32'hDEF);
        check("R10 irq stays after default read", 32'(irq), 1);
        set_req(16'h0210);
        peek(5, d); check("R10 nothing in service", d, 32'hA4);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #2;
        t_reset();
        t_routing();
        t_enable();
        t_vector();
        t_service();
        t_nonvec();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule